// File: doc/BRIEF.md
# Programmable Sum-of-Products Array Emulator

This block behaves like a small field-configurable logic device. Four logic inputs are each offered to a programmable AND plane twice, once as the input itself and once inverted. That gives eight array lines. Sixteen product terms are each built as the AND of whichever lines are connected to them. A fixed OR plane then combines the terms in consecutive groups of four, which gives four sum outputs.

Every sum output passes through its own output cell. The cell can be set to capture the sum in a D flip-flop on the common clock, or to pass the sum straight through. One common output-enable input marks all outputs as driven or undriven. The undriven state is shown by a per-output valid flag, not by a tristate.

The whole configuration is 148 bits. It arrives one bit per cycle on a serial load port. It is gathered in a shadow register and becomes active only when the final bit lands. A one-cycle done pulse marks that moment. The array can therefore be reprogrammed while it runs, without passing through partial states.

Top module: `sop_array_emu`

## Requirements
- R1: Array line 2i carries input `din[i]` and array line 2i+1 carries its complement, for i = 0..3. Connection bit (t, l) sits at configuration index 20 + 8t + l, and a 1 there connects line l to term t.
- R2: When term t's enable bit (configuration index 4 + t) is 1, the term equals the AND of all lines connected to it. A term with no connected lines then evaluates to 1.
- R3: When a term's enable bit is 0, the term contributes 0 to its OR group, whatever its connection bits are.
- R4: Output o is the OR of terms 4o, 4o+1, 4o+2 and 4o+3, with no other term able to affect it.
- R5: When output o's mode bit (configuration index o) is 0, `dout[o]` follows the current OR result combinationally, so an input change shows in the same cycle.
- R6: When output o's mode bit is 1, `dout[o]` shows the OR result captured at the most recent rising clock edge, and it changes only at rising edges. On the edge that activates a new configuration, the flip-flop captures the result of the configuration that was in force before that edge.
- R7: Configuration bits enter on cycles with `ld_en` high, most significant index (147) first. The rising edge that takes the 148th bit makes the new configuration active. `ld_done` is high for exactly the following cycle, and loading continues with a fresh 148-bit frame.
- R8: While a frame is only partly shifted in, the active configuration, the output flip-flops and the outputs behave exactly as if no loading were taking place.
- R9: A synchronous reset clears the output flip-flops, the active configuration and the bit count of a partly loaded frame. After reset, every output reads 0 and the next frame starts at index 147.
- R10: While `oe` is 0, every `dout_vld` bit is 0 and every `dout` bit is forced to 0. While `oe` is 1, every `dout_vld` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for output flip-flops and loader |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 4 | Logic inputs to the array |
| oe | input | 1 | Common output enable |
| ld_en | input | 1 | A configuration bit is presented this cycle |
| ld_bit | input | 1 | Serial configuration data, highest index first |
| ld_done | output | 1 | One-cycle pulse after the last bit of a frame |
| dout | output | 4 | Sum outputs, 0 while not enabled |
| dout_vld | output | 4 | Per-output driven flag |

## Verification
The sharpest overlap is the edge that takes the final bit of a frame while an output is in registered mode. On that one edge the flip-flop captures a sum and the configuration that produces that sum is replaced. The bench loads a registered configuration and then a different one, keeping the inputs changing throughout the shift. A reference model computes each sum from the configuration held before the edge and only afterwards applies the new frame. The registered value that follows is judged against the old configuration, and the combinational outputs in the same cycle against the new one. A reset in the middle of a frame is also provoked, and the bench checks that the next complete frame is still decoded from index 147 down.

// File: rtl/sop_pkg.sv
package sop_pkg;

   typedef enum logic {
      MC_COMB = 1'b0,
      MC_REG  = 1'b1
   } mc_mode_e;

   function automatic int cfg_bits(int n_in, int n_terms, int n_out);
      return n_terms * 2 * n_in + n_terms + n_out;
   endfunction

endpackage

// File: rtl/sop_cfg_loader.sv
module sop_cfg_loader #(
   parameter int CFG_BITS = 148
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                ld_en,
   input  logic                ld_bit,
   output logic [CFG_BITS-1:0] cfg_q,
   output logic                ld_done
);
   localparam int CNT_W = (CFG_BITS > 1) ? $clog2(CFG_BITS) : 1;
   localparam int LAST  = CFG_BITS - 1;

   logic [CFG_BITS-2:0] shadow;
   logic [CNT_W-1:0]    cnt;

   generate
      if (CFG_BITS < 2) begin : g_bad_len
         $error("sop_cfg_loader: CFG_BITS must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         shadow  <= '0;
         cnt     <= '0;
         cfg_q   <= '0;
         ld_done <= 1'b0;
      end else begin
         ld_done <= 1'b0;
         if (ld_en) begin
            shadow <= {shadow[CFG_BITS-3:0], ld_bit};
            if (cnt == CNT_W'(LAST)) begin
               cfg_q   <= {shadow, ld_bit};
               cnt     <= '0;
               ld_done <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R7: done pulse only follows an accepted load bit
   assert_done_after_bit_R7: assert property (@(posedge clk) disable iff (rst)
      ld_done |-> $past(ld_en));

   // R7: done is a single-cycle pulse
   assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
      ld_done |=> !ld_done);

   // R7: bit count stays inside one frame
   assert_cnt_range_R7: assert property (@(posedge clk) disable iff (rst)
      cnt <= CNT_W'(LAST));

   // R8: active configuration only moves when a frame completes
   assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && !ld_done) |-> $stable(cfg_q));

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
   parameter int N_IN    = 4,
   parameter int N_TERMS = 16
) (
   input  logic [N_IN-1:0]              din,
   input  logic [N_TERMS*2*N_IN-1:0]    conn,
   input  logic [N_TERMS-1:0]           term_en,
   output logic [N_TERMS-1:0]           terms
);
   localparam int N_LINES = 2 * N_IN;

   logic [N_LINES-1:0] lines;

   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_line
         assign lines[2*i]   = din[i];
         assign lines[2*i+1] = ~din[i];
      end

      for (genvar t = 0; t < N_TERMS; t++) begin : g_term
         logic [N_LINES-1:0] pass;
         assign pass     = lines | ~conn[t*N_LINES +: N_LINES];
         assign terms[t] = term_en[t] & (&pass);
      end
   endgenerate

endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
   import sop_pkg::*;
#(
   parameter int GROUP = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [GROUP-1:0] grp,
   input  mc_mode_e         mode,
   input  logic             oe,
   output logic             q,
   output logic             vld
);
   logic sum;
   logic ff;

   assign sum = |grp;

   always_ff @(posedge clk) begin
      if (rst) ff <= 1'b0;
      else     ff <= sum;
   end

   always_comb begin
      vld = oe;
      if (!oe)                 q = 1'b0;
      else if (mode == MC_REG) q = ff;
      else                     q = sum;
   end

   // R9: flip-flop is cleared on the edge after reset
   assert_rst_clear_R9: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (ff == 1'b0));

   // R10: an undriven output reads 0
   assert_hidden_zero_R10: assert property (@(posedge clk) disable iff (rst)
      !vld |-> !q);

endmodule

// File: rtl/sop_array_emu.sv
module sop_array_emu
   import sop_pkg::*;
#(
   parameter int N_IN    = 4,
   parameter int N_TERMS = 16,
   parameter int N_OUT   = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_IN-1:0]  din,
   input  logic             oe,
   input  logic             ld_en,
   input  logic             ld_bit,
   output logic             ld_done,
   output logic [N_OUT-1:0] dout,
   output logic [N_OUT-1:0] dout_vld
);
   localparam int N_LINES   = 2 * N_IN;
   localparam int GROUP     = N_TERMS / N_OUT;
   localparam int CONN_BITS = N_TERMS * N_LINES;
   localparam int CFG_BITS  = cfg_bits(N_IN, N_TERMS, N_OUT);

   generate
      if (N_IN < 1 || N_OUT < 1) begin : g_bad_dims
         $error("sop_array_emu: need at least one input and one output");
      end
      if (N_TERMS % N_OUT != 0) begin : g_bad_group
         $error("sop_array_emu: N_TERMS must be a multiple of N_OUT");
      end
   endgenerate

   logic [CFG_BITS-1:0]  cfg;
   logic [N_OUT-1:0]     reg_sel;
   logic [N_TERMS-1:0]   term_en;
   logic [CONN_BITS-1:0] conn;
   logic [N_TERMS-1:0]   terms;

   assign reg_sel = cfg[N_OUT-1:0];
   assign term_en = cfg[N_OUT +: N_TERMS];
   assign conn    = cfg[N_OUT+N_TERMS +: CONN_BITS];

   sop_cfg_loader #(
      .CFG_BITS (CFG_BITS)
   ) u_loader (
      .clk     (clk),
      .rst     (rst),
      .ld_en   (ld_en),
      .ld_bit  (ld_bit),
      .cfg_q   (cfg),
      .ld_done (ld_done)
   );

   sop_and_plane #(
      .N_IN    (N_IN),
      .N_TERMS (N_TERMS)
   ) u_plane (
      .din     (din),
      .conn    (conn),
      .term_en (term_en),
      .terms   (terms)
   );

   generate
      for (genvar o = 0; o < N_OUT; o++) begin : g_out
         mc_mode_e mode;
         assign mode = mc_mode_e'(reg_sel[o]);

         sop_macrocell #(
            .GROUP (GROUP)
         ) u_cell (
            .clk  (clk),
            .rst  (rst),
            .grp  (terms[o*GROUP +: GROUP]),
            .mode (mode),
            .oe   (oe),
            .q    (dout[o]),
            .vld  (dout_vld[o])
         );

         // R5: combinational cell tracks its product group directly
         assert_comb_path_R5: assert property (@(posedge clk) disable iff (rst)
            (mode == MC_COMB && oe) |-> (dout[o] == (|terms[o*GROUP +: GROUP])));
      end
   endgenerate

endmodule

// File: tb/sop_array_emu_bench.sv
module sop_array_emu_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NT = 16;
   localparam int NO = 4;
   localparam int NL = 8;
   localparam int CB = 148;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] din = 4'h0;
   logic       oe = 1'b0;
   logic       ld_en = 1'b0;
   logic       ld_bit = 1'b0;
   logic       ld_done;
   logic [3:0] dout;
   logic [3:0] dout_vld;

   int    n_checks = 0;
   int    n_err = 0;
   string cur_tag = "R9";
   bit    finished = 0;

   sop_array_emu u_sop_array_emu (
      .clk(clk), .rst(rst), .din(din), .oe(oe), .ld_en(ld_en), .ld_bit(ld_bit),
      .ld_done(ld_done), .dout(dout), .dout_vld(dout_vld)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference
   bit          m_conn [NT][NL];
   bit          m_en   [NT];
   bit          m_rs   [NO];
   bit          m_ff   [NO];
   logic [CB-1:0] m_shadow = '0;
   int          m_cnt = 0;
   bit          m_done = 0;

   function automatic bit m_sum(int o, logic [3:0] d);
      for (int k = 0; k < 4; k++) begin
         int t = o * 4 + k;
         if (m_en[t]) begin
            bit p = 1;
            for (int l = 0; l < NL; l++) begin
               if (m_conn[t][l]) begin
                  bit line = (l % 2 == 0) ? d[l/2] : !d[l/2];
                  if (!line) p = 0;
               end
            end
            if (p) return 1;
         end
      end
      return 0;
   endfunction

   task automatic m_apply(logic [CB-1:0] v);
      for (int t = 0; t < NT; t++) begin
         m_en[t] = v[4 + t];
         for (int l = 0; l < NL; l++) m_conn[t][l] = v[20 + t*8 + l];
      end
      for (int o = 0; o < NO; o++) m_rs[o] = v[o];
   endtask

   always @(posedge clk) begin : model
      bit s [NO];
      if (rst) begin
         m_apply('0);
         for (int o = 0; o < NO; o++) m_ff[o] = 0;
         m_cnt = 0;
         m_done = 0;
         m_shadow = '0;
      end else begin
         for (int o = 0; o < NO; o++) s[o] = m_sum(o, din);
         for (int o = 0; o < NO; o++) m_ff[o] = s[o];
         m_done = 0;
         if (ld_en) begin
            m_shadow[CB-1-m_cnt] = ld_bit;
            m_cnt++;
            if (m_cnt == CB) begin
               m_apply(m_shadow);
               m_cnt = 0;
               m_done = 1;
            end
         end
      end
   end

   task automatic chk(string tag, string what, logic got, logic exp);
      n_checks++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s %s got=%b exp=%b t=%0t", tag, what, got, exp, $time);
      end
   endtask

   task automatic compare_all();
      for (int o = 0; o < NO; o++) begin
         bit e = oe ? (m_rs[o] ? m_ff[o] : m_sum(o, din)) : 1'b0;
         chk(cur_tag, $sformatf("dout[%0d]", o), dout[o], e);
         chk("R10", $sformatf("dout_vld[%0d]", o), dout_vld[o], oe);
      end
      chk("R7", "ld_done", ld_done, m_done);
   endtask

   task automatic step(logic [3:0] d, logic o, logic le, logic lb);
      @(negedge clk);
      din = d; oe = o; ld_en = le; ld_bit = lb;
      #1;
      compare_all();
   endtask

   logic [CB-1:0] cv;

   task automatic set_conn(int t, int l); cv[20 + t*8 + l] = 1'b1; endtask
   task automatic set_en(int t);          cv[4 + t] = 1'b1;        endtask
   task automatic set_rs(int o);          cv[o] = 1'b1;            endtask

   task automatic load_cfg();
      string keep = cur_tag;
      cur_tag = "R8";
      for (int k = 0; k < CB; k++) step(4'(k), 1'b1, 1'b1, cv[CB-1-k]);
      cur_tag = keep;
      step(4'h0, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic sweep(string tag);
      cur_tag = tag;
      for (int d = 0; d < 16; d++) step(4'(d), 1'b1, 1'b0, 1'b0);
      for (int d = 15; d >= 0; d -= 3) step(4'(d), 1'b1, 1'b0, 1'b0);
   endtask

   initial begin
      // R9: reset state
      cur_tag = "R9";
      rst = 1'b1;
      step(4'h5, 1'b0, 1'b0, 1'b0);
      step(4'ha, 1'b1, 1'b0, 1'b0);
      rst = 1'b0;
      step(4'hf, 1'b1, 1'b0, 1'b0);

      // R1 R2: term0 = in0 & ~in1, term4 empty and enabled, all combinational
      cv = '0;
      set_conn(0, 0); set_conn(0, 3); set_en(0);
      set_en(4);
      set_conn(8, 5); set_conn(8, 6); set_en(8);
      cur_tag = "R2";
      load_cfg();
      sweep("R1");
      sweep("R2");

      // R3: same connections but terms disabled
      cv[4 + 4] = 1'b0;
      cv[4 + 0] = 1'b0;
      load_cfg();
      sweep("R3");

      // R4: only the last term of each group drives, plus a term outside group 1
      cv = '0;
      set_conn(3, 6); set_en(3);
      set_conn(7, 1); set_en(7);
      set_conn(11, 2); set_conn(11, 4); set_en(11);
      set_conn(12, 7); set_en(12);
      set_conn(15, 0); set_en(15);
      load_cfg();
      sweep("R4");

      // R5: combinational path observed every cycle
      sweep("R5");

      // R6: same array, all cells registered; the last load edge collides with capture
      set_rs(0); set_rs(1); set_rs(2); set_rs(3);
      cur_tag = "R6";
      load_cfg();
      sweep("R6");
      cv = '0;
      set_en(0); set_en(5); set_conn(5, 2); set_en(10); set_conn(10, 3);
      set_rs(0); set_rs(2);
      load_cfg();
      sweep("R6");

      // R10: output enable toggling
      cur_tag = "R10";
      for (int k = 0; k < 12; k++) step(4'(k * 5), 1'(k % 2), 1'b0, 1'b0);

      // R9: reset in the middle of a frame, then a full frame decodes from index 147
      cur_tag = "R9";
      for (int k = 0; k < 50; k++) step(4'(k), 1'b1, 1'b1, 1'b1);
      rst = 1'b1;
      step(4'h3, 1'b1, 1'b0, 1'b0);
      rst = 1'b0;
      step(4'h3, 1'b1, 1'b0, 1'b0);
      cv = '0;
      set_en(1); set_conn(1, 0); set_rs(1);
      set_en(13);
      load_cfg();
      sweep("R9");

      // R7: back-to-back frames
      cur_tag = "R7";
      cv = '0;
      set_en(2); set_en(6); set_conn(6, 7);
      for (int k = 0; k < CB; k++) step(4'(k), 1'b1, 1'b1, cv[CB-1-k]);
      cv = '0;
      set_en(9); set_conn(9, 4); set_rs(2);
      load_cfg();
      sweep("R7");

      // mixed random configurations
      for (int r = 0; r < 6; r++) begin
         cv = '0;
         for (int k = 0; k < CB; k++) begin
            if (k >= 20) cv[k] = ($urandom % 5) == 0;
            else         cv[k] = $urandom % 2;
         end
         cur_tag = "R4";
         load_cfg();
         for (int k = 0; k < 40; k++)
            step(4'($urandom), 1'($urandom % 8 != 0), 1'b0, 1'b0);
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_err++;
         n_checks++;
         $display("FAIL watchdog expired (all requirements)");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

endmodule